// File: doc/BRIEF.md
# Interlaced Video Field Detector

This block decides, field by field, whether interlaced video arrives as an odd or an even field. The decision comes from sync timing alone. A counter restarts on every active edge of horizontal sync. When vertical sync becomes active, the counter value is taken as this field's phase. The block compares it with the phase stored from the field before: a later phase means even, an earlier one means odd. The result is stored as a field flag.

The block also drives a dot-line select for characters drawn at half-line vertical size, so that alternate fields show alternate dot lines. One 8-bit control register sets the polarity of each sync input and the pairing of dot lines with fields. Software can read the field flag through the same register. Both sync inputs are asynchronous to the clock and pass through two-flop synchronizers.

Top module: `fd_field_detect`

## Requirements
- R1: After reset, both polarity bits are 0 and the line-select bit is 0. With a polarity bit at 0, the rising edge of that sync input is its active edge.
- R2: With a polarity bit at 1, the falling edge is the active edge. A polarity write that makes the corrected level rise counts as an active edge.
- R3: The phase is the number of clocks from the most recent horizontal active edge to the vertical active edge. Every horizontal active edge, including one inside the same field, restarts the count.
- R4: A phase larger than the stored one sets the flag to 0 (even). A smaller phase sets the flag to 1 (odd).
- R5: A phase equal to the stored one leaves the flag unchanged. In every case the new phase becomes the stored value.
- R6: The flag resets to 1. The first vertical active edge after reset only stores the phase and leaves the flag unchanged.
- R7: The phase counter saturates at 2^CNT_W-1 and does not wrap.
- R8: The flag is read-only: writing bit 7 of the register has no effect.
- R9: dot_line_o equals the flag XOR the line-select bit.
- R10: The flag changes only in response to a vertical active edge. The new value appears on the third rising clock edge after vsync_i changes, or on the second edge after a polarity write.
- R11: Register layout: bit 0 sets horizontal polarity, bit 1 sets vertical polarity, bit 2 is line select, bits 6..3 read 0, and bit 7 reads the flag. A write takes effect on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| hsync_i | input | 1 | Horizontal sync, asynchronous |
| vsync_i | input | 1 | Vertical sync, asynchronous |
| reg_we_i | input | 1 | Control register write strobe |
| reg_wdata_i | input | 8 | Control register write data |
| reg_rdata_o | output | 8 | Control register read data |
| field_odd_o | output | 1 | Field flag, 1 = odd |
| dot_line_o | output | 1 | Dot line for half-line display |

## Verification
The assertions assume that a horizontal edge and a vertical edge never reach the detector in the same clock. They also assume that each sync pulse lasts at least two clocks, so the synchronizers never miss a pulse. The stimulus keeps every horizontal pulse at least three clocks away from the vertical pulse that follows it, and it holds each pulse for two or three clocks. Polarity changes are issued one bit at a time while the raw lines sit still, so each change produces at most one edge, and the reference model predicts that edge.

// File: rtl/fd_pkg.sv
package fd_pkg;
  localparam int REG_W        = 8;
  localparam int HS_POL_BIT   = 0;
  localparam int VS_POL_BIT   = 1;
  localparam int LINE_SEL_BIT = 2;
  localparam int FIELD_BIT    = 7;
  localparam int N_SYNC       = 2;

  typedef enum int unsigned {
    SYNC_H = 0,
    SYNC_V = 1
  } sync_idx_e;

  typedef struct packed {
    logic line_sel;
    logic vs_neg;
    logic hs_neg;
  } fd_ctrl_t;
endpackage

// File: rtl/fd_sync_edge.sv
module fd_sync_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  input  logic neg_i,
  output logic act_o
);
  logic s1_q, s2_q, lvl_d_q;
  logic lvl;

  assign lvl = s2_q ^ neg_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q    <= 1'b0;
      s2_q    <= 1'b0;
      lvl_d_q <= 1'b0;
    end else begin
      s1_q    <= raw_i;
      s2_q    <= s1_q;
      lvl_d_q <= lvl;
    end
  end

  assign act_o = lvl & ~lvl_d_q;
endmodule

// File: rtl/fd_interval.sv
module fd_interval #(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             h_act_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_o <= '0;
    else if (h_act_i)          cnt_o <= '0;
    else if (cnt_o != CNT_MAX) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/fd_field_cmp.sv
module fd_field_cmp #(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             v_act_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             field_odd_o
);
  logic [CNT_W-1:0] ref_q;
  logic             ref_vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q       <= '0;
      ref_vld_q   <= 1'b0;
      field_odd_o <= 1'b1;
    end else if (v_act_i) begin
      ref_q     <= cnt_i;
      ref_vld_q <= 1'b1;
      // first field only seeds the reference
      if (ref_vld_q) begin
        if (cnt_i > ref_q)      field_odd_o <= 1'b0;
        else if (cnt_i < ref_q) field_odd_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/fd_field_detect.sv
module fd_field_detect
  import fd_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hsync_i,
  input  logic             vsync_i,
  input  logic             reg_we_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  output logic             field_odd_o,
  output logic             dot_line_o
);
  fd_ctrl_t         ctrl_q;
  logic [N_SYNC-1:0] raw, neg, act;
  logic             h_act, v_act;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (reg_we_i) begin
      ctrl_q.hs_neg   <= reg_wdata_i[HS_POL_BIT];
      ctrl_q.vs_neg   <= reg_wdata_i[VS_POL_BIT];
      ctrl_q.line_sel <= reg_wdata_i[LINE_SEL_BIT];
    end
  end

  assign raw[SYNC_H] = hsync_i;
  assign raw[SYNC_V] = vsync_i;
  assign neg[SYNC_H] = ctrl_q.hs_neg;
  assign neg[SYNC_V] = ctrl_q.vs_neg;

  for (genvar g = 0; g < N_SYNC; g++) begin : g_sync
    fd_sync_edge i_edge (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .raw_i (raw[g]),
      .neg_i (neg[g]),
      .act_o (act[g])
    );
  end

  assign h_act = act[SYNC_H];
  assign v_act = act[SYNC_V];

  fd_interval #(.CNT_W(CNT_W)) i_interval (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .h_act_i(h_act),
    .cnt_o  (cnt_q)
  );

  fd_field_cmp #(.CNT_W(CNT_W)) i_cmp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .v_act_i    (v_act),
    .cnt_i      (cnt_q),
    .field_odd_o(field_odd_o)
  );

  assign dot_line_o = field_odd_o ^ ctrl_q.line_sel;

  always_comb begin
    reg_rdata_o               = '0;
    reg_rdata_o[HS_POL_BIT]   = ctrl_q.hs_neg;
    reg_rdata_o[VS_POL_BIT]   = ctrl_q.vs_neg;
    reg_rdata_o[LINE_SEL_BIT] = ctrl_q.line_sel;
    reg_rdata_o[FIELD_BIT]    = field_odd_o;
  end
endmodule

// File: rtl/fd_field_detect_chk.sv
module fd_field_detect_chk #(
  parameter int CNT_W = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             h_act_i,
  input logic             v_act_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic             field_odd_i,
  input logic             dot_line_i,
  input logic             line_sel_i
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  p_cnt_restart_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    h_act_i |=> (cnt_i == '0));

  p_cnt_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!h_act_i && cnt_i != CNT_MAX) |=> (cnt_i == $past(cnt_i) + 1'b1));

  p_no_wrap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!h_act_i && cnt_i == CNT_MAX) |=> (cnt_i == CNT_MAX));

  p_flag_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !v_act_i |=> $stable(field_odd_i));

  p_dot_follows_flag_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($stable(line_sel_i) && !$stable(field_odd_i)) |-> !$stable(dot_line_i));

  p_dot_follows_sel_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(line_sel_i) && $stable(field_odd_i)) |-> !$stable(dot_line_i));
endmodule

bind fd_field_detect fd_field_detect_chk #(.CNT_W(CNT_W)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .h_act_i    (h_act),
  .v_act_i    (v_act),
  .cnt_i      (cnt_q),
  .field_odd_i(field_odd_o),
  .dot_line_i (dot_line_o),
  .line_sel_i (ctrl_q.line_sel)
);

// File: tb/test_fd_field_detect.sv
module test_fd_field_detect;
  localparam int CNT_W = 6;
  localparam int MAXV  = (1 << CNT_W) - 1;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic hsync = 1'b0, vsync = 1'b0, reg_we = 1'b0;
  logic [7:0] wdata = '0, rdata;
  logic field_odd, dot_line;

  always #4 clk = ~clk;

  fd_field_detect #(.CNT_W(CNT_W)) i_fd_field_detect (
    .clk_i(clk), .rst_ni(rst_ni), .hsync_i(hsync), .vsync_i(vsync),
    .reg_we_i(reg_we), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .field_odd_o(field_odd), .dot_line_o(dot_line)
  );

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;
  string cur_req = "R6";

  // reference model state
  int  last_h = 0, ref_v = 0;
  bit  ref_ok = 0, m_logic = 1, m_flag = 1;
  bit  pf_v = 0, pf = 1; int pf_c = 0;
  bit  pr_v = 0; logic [2:0] pr = '0, m_ctrl = '0; int pr_c = 0;
  bit  corr_h = 0, corr_v = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h cyc=%0d", req, act, exp, cyc);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic void h_event(int e);
    last_h = e;
  endfunction

  function automatic void v_event(int e);
    int d = e - last_h - 1;
    if (d > MAXV) d = MAXV;
    if (ref_ok) begin
      if (d > ref_v)      m_logic = 0;
      else if (d < ref_v) m_logic = 1;
    end
    ref_ok = 1; ref_v = d;
    pf = m_logic; pf_c = e; pf_v = 1;
  endfunction

  // raw input change: effective on third edge
  task automatic drive_h(logic v);
    bit n = v ^ m_ctrl_next()[0];
    hsync = v;
    if (n && !corr_h) h_event(cyc + 3);
    corr_h = n;
  endtask

  task automatic drive_v(logic v);
    bit n = v ^ m_ctrl_next()[1];
    vsync = v;
    if (n && !corr_v) v_event(cyc + 3);
    corr_v = n;
  endtask

  function automatic logic [2:0] m_ctrl_next();
    return pr_v ? pr : m_ctrl;
  endfunction

  // polarity write: corrected level moves on next edge, detected one later
  task automatic wr(logic [7:0] d);
    bit nh = hsync ^ d[0];
    bit nv = vsync ^ d[1];
    if (nh && !corr_h) h_event(cyc + 2);
    if (nv && !corr_v) v_event(cyc + 2);
    corr_h = nh; corr_v = nv;
    pr = d[2:0]; pr_c = cyc + 1; pr_v = 1;
    reg_we = 1'b1; wdata = d;
    tick(1);
    reg_we = 1'b0;
  endtask

  task automatic field(int phase, bit extra_h);
    logic act = m_ctrl_next()[0] ? 1'b0 : 1'b1;
    logic actv = m_ctrl_next()[1] ? 1'b0 : 1'b1;
    if (extra_h) begin
      drive_h(act); tick(2); drive_h(~act); tick(15);
    end
    drive_h(act); tick(2); drive_h(~act); tick(phase - 2);
    drive_v(actv); tick(3); drive_v(~actv); tick(30);
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_ni && !done) begin
      if (pf_v && cyc >= pf_c) begin m_flag = pf; pf_v = 0; end
      if (pr_v && cyc >= pr_c) begin m_ctrl = pr; pr_v = 0; end
      check(field_odd == m_flag, cur_req, field_odd, m_flag);
      check(dot_line == (m_flag ^ m_ctrl[2]), "R9", dot_line, m_flag ^ m_ctrl[2]);
      check(rdata == {m_flag, 4'b0, m_ctrl}, "R11", rdata, {m_flag, 4'b0, m_ctrl});
    end
  end

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc > 20000 && !done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=<20000", cyc);
      finish_run();
    end
  end

  initial begin
    tick(3);
    rst_ni = 1'b1;
    tick(1);
    check(rdata == 8'h80, "R1", rdata, 8'h80);
    check(field_odd == 1'b1, "R6", field_odd, 1);
    cur_req = "R6";  field(20, 0);   // seeds reference only
    check(field_odd == 1'b1, "R6", field_odd, 1);
    cur_req = "R4";  field(31, 0);   // longer -> even
    check(field_odd == 1'b0, "R4", field_odd, 0);
    field(26, 0);                    // shorter -> odd
    check(field_odd == 1'b1, "R4", field_odd, 1);
    cur_req = "R5";  field(26, 0);
    check(field_odd == 1'b1, "R5", field_odd, 1);
    cur_req = "R4";  field(41, 0);
    cur_req = "R5";  field(41, 0);
    check(field_odd == 1'b0, "R5", field_odd, 0);
    cur_req = "R3";  field(21, 1);   // extra early pulse must not count
    check(field_odd == 1'b1, "R3", field_odd, 1);
    cur_req = "R7";  field(100, 0);  // saturates
    check(field_odd == 1'b0, "R7", field_odd, 0);
    field(120, 0);                   // both saturated -> equal
    check(field_odd == 1'b0, "R7", field_odd, 0);
    field(10, 0);
    check(field_odd == 1'b1, "R7", field_odd, 1);
    cur_req = "R8";  wr(8'h00); tick(3);
    wr(8'h80); tick(3);
    check(rdata == 8'h80, "R8", rdata, 8'h80);
    cur_req = "R10"; wr(8'h04); tick(3);
    check(dot_line == 1'b0, "R9", dot_line, 0);
    field(40, 0);
    check(dot_line == 1'b1, "R9", dot_line, 1);
    cur_req = "R2";  wr(8'h05); tick(10);
    wr(8'h07); tick(10);
    drive_h(1'b1); drive_v(1'b1); tick(40);
    field(30, 0);
    field(15, 0);
    check(field_odd == 1'b1, "R2", field_odd, 1);
    field(45, 1);
    check(field_odd == 1'b0, "R2", field_odd, 0);
    cur_req = "R10"; field(45, 0);
    tick(5);
    finish_run();
  end
endmodule